// File: doc/BRIEF.md
# Bit-Plane Population Eraser

This block cleans one code block of a high-frequency wavelet sub-band before it reaches the entropy coder. Bits arrive one bit-plane at a time, most significant plane first, as a valid/ready stream of fixed-width lanes. The block buffers a whole plane and counts its ones. If the plane holds fewer ones than a threshold supplied at run time, which is normally set to twice the expected number of memory upsets per plane, the plane is sent on as all zeros and flagged so the coder can skip it. The first plane that keeps its content switches erasure off for the rest of the block. All later planes are forwarded bit for bit.

Two other behaviours are selected per block. A fixed mode blanks a set number of top planes without counting. That number is clamped to between two and four. A low-pass band flag turns off all erasure, because the lowest-frequency band is never cleaned this way. A one-cycle start pulse marks a new code block. It rearms the block and captures the configuration pins.

Back-pressure: an input beat transfers on a clock edge where `in_valid` and `in_ready` are both high. An output beat transfers where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the output beat and its flags are held unchanged. The input side stalls (`in_ready` low) while a buffered plane is being drained.

Top module: `bitplane_eraser`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: A plane is PLANE_LEN/LANE_W beats (64 beats of 16 bits by default), and lane bit j of beat b is plane bit b*16+j. No beat of a plane is presented at the output before every beat of that plane has been accepted. `in_ready` and `out_valid` are never high together. `out_eop` is high exactly on the last beat of each output plane.
- R3: In counting mode, while the block is armed, a plane whose count of ones is below the captured threshold is output with every beat zero and `out_zero` high on all of its beats.
- R4: In counting mode, the first plane that is not erased disarms the block. That plane and every later plane of the block are output identical to the input, with `out_zero` low.
- R5: The ones count saturates at 2^CNT_W-1 (511), so a plane with more ones than that is never erased because of counter wrap-around.
- R6: In fixed mode, plane k of the block (k = 0 for the most significant plane) is erased when k < clamp(cfg_fixed_n, 2, 4), whatever its content. All other planes pass through unchanged.
- R7: With the low-pass band flag captured high, no plane is erased.
- R8: A `blk_start` pulse resets the plane index, the counter and the armed state, and captures `cfg_thr`, `cfg_fixed`, `cfg_fixed_n` and `cfg_ll`. Changes to those pins after the pulse have no effect on the current block.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_bits`, `out_zero` and `out_eop` stay unchanged in the next cycle. Gaps in `in_valid` lose no data.
- R10: A captured threshold of 0 never erases a plane, even one that holds no ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_start | input | 1 | One-cycle pulse marking a new code block |
| cfg_thr | input | CNT_W | Erasure threshold for counting mode |
| cfg_fixed | input | 1 | 1 selects fixed top-plane mode |
| cfg_fixed_n | input | FN_W | Number of top planes blanked in fixed mode (clamped to 2..4) |
| cfg_ll | input | 1 | 1 marks the low-pass band and disables erasure |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block accepts an input beat |
| in_bits | input | LANE_W | Input lane bits of the current plane |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts an output beat |
| out_bits | output | LANE_W | Corrected lane bits |
| out_zero | output | 1 | Current output plane was erased |
| out_eop | output | 1 | Last beat of the current output plane |

## Verification
The bench aims at the plane whose count equals the threshold. It must survive and stop the scan. A design that used "at most" would erase it and also blank the planes below. A plane with 1024 ones is run against a threshold of 511, so a wrapping counter would read it as nearly empty and erase real data. The fixed-mode count is driven below, inside and above its legal range to catch a missing clamp. The configuration pins are changed right after the start pulse to catch a design that reads them live. Output stalls and input gaps are mixed in throughout, so a design that advanced its read pointer while stalled would drop or repeat beats.

// File: rtl/bpe_pkg.sv
package bpe_pkg;
  typedef enum logic {
    ST_FILL  = 1'b0,
    ST_DRAIN = 1'b1
  } bpe_state_e;
endpackage

// File: rtl/bpe_popsat.sv
// Saturating accumulator of lane population for one bit-plane.
module bpe_popsat #(
  parameter int LANE_W = 16,
  parameter int CNT_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [LANE_W-1:0] lane,
  output logic [CNT_W-1:0]  cnt_next
);
  localparam int PW = $clog2(LANE_W + 1);
  localparam int SW = CNT_W + 1;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] cnt;
  logic [PW-1:0]    pop;
  logic [SW-1:0]    sum;

  always_comb begin
    pop = '0;
    for (int i = 0; i < LANE_W; i++) begin
      pop = pop + PW'(lane[i]);
    end
    sum = SW'(cnt) + SW'(pop);
    cnt_next = (sum > SW'(CMAX)) ? CMAX : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= cnt_next;
  end
endmodule

// File: rtl/bpe_policy.sv
// Erase decision for the plane that has just been fully counted.
module bpe_policy #(
  parameter int CNT_W   = 9,
  parameter int PIDX_W  = 5,
  parameter int FN_W    = 3,
  parameter int FIX_MIN = 2,
  parameter int FIX_MAX = 4
) (
  input  logic [CNT_W-1:0]  plane_cnt,
  input  logic [CNT_W-1:0]  thr,
  input  logic              fixed,
  input  logic [FN_W-1:0]   fixed_n,
  input  logic              ll,
  input  logic              armed,
  input  logic [PIDX_W-1:0] pidx,
  output logic              erase,
  output logic              disarm
);
  localparam logic [FN_W-1:0] N_LO = FN_W'(FIX_MIN);
  localparam logic [FN_W-1:0] N_HI = FN_W'(FIX_MAX);

  logic [FN_W-1:0] n_eff;
  logic            erase_fix;
  logic            erase_cnt;

  always_comb begin
    if (fixed_n < N_LO)      n_eff = N_LO;
    else if (fixed_n > N_HI) n_eff = N_HI;
    else                     n_eff = fixed_n;
    erase_fix = int'(pidx) < int'(n_eff);
    erase_cnt = armed && (plane_cnt < thr);
    if (ll) begin
      erase  = 1'b0;
      disarm = 1'b0;
    end else if (fixed) begin
      erase  = erase_fix;
      disarm = 1'b0;
    end else begin
      erase  = erase_cnt;
      disarm = armed && !erase_cnt;
    end
  end
endmodule

// File: rtl/bpe_planebuf.sv
// Storage for one bit-plane, written while filling and read while draining.
module bpe_planebuf #(
  parameter int W     = 16,
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/bitplane_eraser.sv
module bitplane_eraser
  import bpe_pkg::*;
#(
  parameter int LANE_W     = 16,
  parameter int PLANE_LEN  = 1024,
  parameter int NUM_PLANES = 16,
  parameter int CNT_W      = 9,
  parameter int FN_W       = 3,
  parameter int FIX_MIN    = 2,
  parameter int FIX_MAX    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_start,
  input  logic [CNT_W-1:0]  cfg_thr,
  input  logic              cfg_fixed,
  input  logic [FN_W-1:0]   cfg_fixed_n,
  input  logic              cfg_ll,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [LANE_W-1:0] in_bits,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LANE_W-1:0] out_bits,
  output logic              out_zero,
  output logic              out_eop
);
  localparam int BEATS  = PLANE_LEN / LANE_W;
  localparam int AW     = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int PIDX_W = $clog2(NUM_PLANES + 1);
  localparam logic [AW-1:0]     LAST_BEAT = AW'(BEATS - 1);
  localparam logic [PIDX_W-1:0] PIDX_MAX  = PIDX_W'(NUM_PLANES);

  bpe_state_e        st;
  logic [AW-1:0]     beat;
  logic [PIDX_W-1:0] pidx;
  logic              armed;
  logic              erase_q;
  logic [CNT_W-1:0]  cfg_thr_q;
  logic              cfg_fixed_q;
  logic [FN_W-1:0]   cfg_fixed_n_q;
  logic              cfg_ll_q;

  logic              acc_in;
  logic              last_in;
  logic              acc_out;
  logic              last_out;
  logic [CNT_W-1:0]  plane_cnt;
  logic              pol_erase;
  logic              pol_disarm;
  logic [LANE_W-1:0] rd_word;

  assign in_ready  = (st == ST_FILL);
  assign out_valid = (st == ST_DRAIN);
  assign acc_in    = in_valid && in_ready;
  assign last_in   = acc_in && (beat == LAST_BEAT);
  assign acc_out   = out_valid && out_ready;
  assign last_out  = acc_out && (beat == LAST_BEAT);

  bpe_popsat #(
    .LANE_W(LANE_W),
    .CNT_W (CNT_W)
  ) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (blk_start || last_in),
    .en      (acc_in),
    .lane    (in_bits),
    .cnt_next(plane_cnt)
  );

  bpe_policy #(
    .CNT_W  (CNT_W),
    .PIDX_W (PIDX_W),
    .FN_W   (FN_W),
    .FIX_MIN(FIX_MIN),
    .FIX_MAX(FIX_MAX)
  ) u_policy (
    .plane_cnt(plane_cnt),
    .thr      (cfg_thr_q),
    .fixed    (cfg_fixed_q),
    .fixed_n  (cfg_fixed_n_q),
    .ll       (cfg_ll_q),
    .armed    (armed),
    .pidx     (pidx),
    .erase    (pol_erase),
    .disarm   (pol_disarm)
  );

  bpe_planebuf #(
    .W    (LANE_W),
    .DEPTH(BEATS),
    .AW   (AW)
  ) u_buf (
    .clk  (clk),
    .we   (acc_in),
    .waddr(beat),
    .wdata(in_bits),
    .raddr(beat),
    .rdata(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= ST_FILL;
      beat          <= '0;
      pidx          <= '0;
      armed         <= 1'b1;
      erase_q       <= 1'b0;
      cfg_thr_q     <= '0;
      cfg_fixed_q   <= 1'b0;
      cfg_fixed_n_q <= '0;
      cfg_ll_q      <= 1'b0;
    end else if (blk_start) begin
      st            <= ST_FILL;
      beat          <= '0;
      pidx          <= '0;
      armed         <= 1'b1;
      erase_q       <= 1'b0;
      cfg_thr_q     <= cfg_thr;
      cfg_fixed_q   <= cfg_fixed;
      cfg_fixed_n_q <= cfg_fixed_n;
      cfg_ll_q      <= cfg_ll;
    end else begin
      unique case (st)
        ST_FILL: begin
          if (last_in) begin
            beat    <= '0;
            st      <= ST_DRAIN;
            erase_q <= pol_erase;
            if (pol_disarm) armed <= 1'b0;
          end else if (acc_in) begin
            beat <= beat + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (last_out) begin
            beat <= '0;
            st   <= ST_FILL;
            if (pidx != PIDX_MAX) pidx <= pidx + 1'b1;
          end else if (acc_out) begin
            beat <= beat + 1'b1;
          end
        end
        default: st <= ST_FILL;
      endcase
    end
  end

  assign out_bits = erase_q ? '0 : rd_word;
  assign out_zero = out_valid && erase_q;
  assign out_eop  = out_valid && (beat == LAST_BEAT);
endmodule

// File: rtl/bitplane_eraser_chk.sv
module bitplane_eraser_chk #(
  parameter int LANE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              blk_start,
  input logic              fixed_q,
  input logic              ll_q,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [LANE_W-1:0] out_bits,
  input logic              out_zero,
  input logic              out_eop
);
  logic kept_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                             kept_seen <= 1'b0;
    else if (blk_start)                                     kept_seen <= 1'b0;
    else if (out_valid && out_ready && out_eop && !out_zero) kept_seen <= 1'b1;
  end

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  a_r3_blank_data: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_zero |-> out_bits == '0);

  a_r3_flag_whole_plane: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_eop && !blk_start |=> out_valid && (out_zero == $past(out_zero)));

  a_r4_no_erase_after_keep: assert property (@(posedge clk) disable iff (!rst_n)
    kept_seen && out_valid && !fixed_q |-> !out_zero);

  a_r7_low_band_kept: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && ll_q |-> !out_zero);

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !blk_start |=> out_valid && $stable(out_bits)
      && $stable(out_zero) && $stable(out_eop));
endmodule

bind bitplane_eraser bitplane_eraser_chk #(.LANE_W(LANE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .blk_start(blk_start),
  .fixed_q  (cfg_fixed_q),
  .ll_q     (cfg_ll_q),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_bits (out_bits),
  .out_zero (out_zero),
  .out_eop  (out_eop)
);

// File: tb/test_bitplane_eraser.sv
`timescale 1ns/1ps
module test_bitplane_eraser;
  localparam int LW = 16;
  localparam int NB = 64;
  localparam int NP = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          blk_start = 1'b0;
  logic [8:0]    cfg_thr = '0;
  logic          cfg_fixed = 1'b0;
  logic [2:0]    cfg_fixed_n = '0;
  logic          cfg_ll = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [LW-1:0] in_bits = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [LW-1:0] out_bits;
  logic          out_zero;
  logic          out_eop;

  int  checks = 0;
  int  failures = 0;
  int  cyc = 0;
  bit  done = 1'b0;
  int  kcnt [NP];
  bit  exp_er [NP];

  always #4 clk = ~clk;

  bitplane_eraser i_bitplane_eraser (
    .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .cfg_thr(cfg_thr),
    .cfg_fixed(cfg_fixed), .cfg_fixed_n(cfg_fixed_n), .cfg_ll(cfg_ll),
    .in_valid(in_valid), .in_ready(in_ready), .in_bits(in_bits),
    .out_valid(out_valid), .out_ready(out_ready), .out_bits(out_bits),
    .out_zero(out_zero), .out_eop(out_eop)
  );

  task automatic check(input string req, input bit ok, input string msg);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  function automatic logic [LW-1:0] gen(input int p, input int b);
    logic [LW-1:0] w;
    for (int j = 0; j < LW; j++) begin
      int i;
      i = b * LW + j;
      w[j] = (((i * 37 + p * 11) % 1024) < kcnt[p]);
    end
    return w;
  endfunction

  task automatic model(input bit fx, input int n, input bit ll, input int thr);
    bit armed;
    int nc;
    armed = 1'b1;
    nc = (n < 2) ? 2 : ((n > 4) ? 4 : n);
    for (int p = 0; p < NP; p++) begin
      int c;
      c = (kcnt[p] > 511) ? 511 : kcnt[p];
      if (ll)      exp_er[p] = 1'b0;
      else if (fx) exp_er[p] = (p < nc);
      else begin
        exp_er[p] = armed && (c < thr);
        if (!exp_er[p]) armed = 1'b0;
      end
    end
  endtask

  task automatic run_block(input string tag, input bit fx, input int n, input bit ll,
                           input int thr, input bit scramble);
    int ip = 0, ib = 0, op = 0, ob = 0;
    int stall_bad = 0, excl_bad = 0, lat_bad = 0, mism = 0;
    logic [LW-1:0] bad_got = '0, bad_exp = '0;
    bit prev_stall = 1'b0;
    logic [LW-1:0] pv_bits = '0;
    logic pv_zero = 1'b0, pv_eop = 1'b0, zero_bad = 1'b0, eop_bad = 1'b0;
    model(fx, n, ll, thr);
    @(negedge clk);
    cfg_fixed = fx; cfg_fixed_n = 3'(n); cfg_ll = ll; cfg_thr = 9'(thr);
    blk_start = 1'b1;
    @(negedge clk);
    blk_start = 1'b0;
    if (scramble) begin
      cfg_fixed = 1'b1; cfg_ll = 1'b1; cfg_thr = '0; cfg_fixed_n = 3'd7;
    end
    while (op < NP && !done) begin
      @(negedge clk);
      cyc++;
      in_valid  = (ip < NP) && (cyc % 7 != 2);
      in_bits   = (ip < NP) ? gen(ip, ib) : '0;
      out_ready = (cyc % 5 != 3);
      if (prev_stall && !(out_valid && out_bits == pv_bits && out_zero == pv_zero
                          && out_eop == pv_eop)) stall_bad++;
      if (in_ready && out_valid) excl_bad++;
      if (out_valid && ip <= op) lat_bad++;
      if (in_valid && in_ready) begin
        ib++;
        if (ib == NB) begin ib = 0; ip++; end
      end
      if (out_valid && out_ready) begin
        logic [LW-1:0] e;
        e = exp_er[op] ? '0 : gen(op, ob);
        if (out_bits !== e) begin
          if (mism == 0) begin bad_got = out_bits; bad_exp = e; end
          mism++;
        end
        if (out_zero !== exp_er[op]) zero_bad = 1'b1;
        if (out_eop !== (ob == NB - 1)) eop_bad = 1'b1;
        ob++;
        if (ob == NB) begin
          check(tag, mism == 0 && !zero_bad,
                $sformatf("plane %0d data got %h exp %h, erased exp %0d mism %0d",
                          op, bad_got, bad_exp, exp_er[op], mism));
          check("R2", !eop_bad, $sformatf("plane %0d end-of-plane marker got misplaced exp beat %0d", op, NB - 1));
          mism = 0; zero_bad = 1'b0; eop_bad = 1'b0;
          ob = 0; op++;
        end
      end
      prev_stall = out_valid && !out_ready;
      pv_bits = out_bits; pv_zero = out_zero; pv_eop = out_eop;
    end
    in_valid = 1'b0;
    check("R9", stall_bad == 0, $sformatf("%s stall changes got %0d exp 0", tag, stall_bad));
    check("R2", excl_bad == 0 && lat_bad == 0,
          $sformatf("%s overlap got %0d early-out got %0d exp 0", tag, excl_bad, lat_bad));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", out_valid == 1'b0, $sformatf("out_valid got %0d exp 0", out_valid));
    check("R1", in_ready == 1'b1, $sformatf("in_ready got %0d exp 1", in_ready));

    // R3 R4: planes with 0,3,9 ones erased at threshold 10, count 10 survives
    for (int p = 0; p < NP; p++) kcnt[p] = (p * 53) % 400;
    kcnt[0] = 0; kcnt[1] = 3; kcnt[2] = 9; kcnt[3] = 10; kcnt[4] = 2; kcnt[5] = 0;
    run_block("R3 R4", 1'b0, 0, 1'b0, 10, 1'b0);

    // R8: rearm after a stopped block, pins changed after the pulse
    for (int p = 0; p < NP; p++) kcnt[p] = (p * 29) % 50;
    kcnt[0] = 4; kcnt[1] = 9; kcnt[2] = 300;
    run_block("R8", 1'b0, 0, 1'b0, 10, 1'b1);

    // R5: fully set plane against maximum threshold
    for (int p = 0; p < NP; p++) kcnt[p] = 3;
    kcnt[0] = 1024; kcnt[1] = 0;
    run_block("R5", 1'b0, 0, 1'b0, 511, 1'b0);

    // R6: fixed mode, in range, above range, below range
    for (int p = 0; p < NP; p++) kcnt[p] = (p * 17) % 90;
    kcnt[0] = 1024; kcnt[1] = 500; kcnt[2] = 7; kcnt[3] = 0;
    run_block("R6", 1'b1, 3, 1'b0, 511, 1'b0);
    run_block("R6", 1'b1, 7, 1'b0, 511, 1'b0);
    run_block("R6", 1'b1, 0, 1'b0, 511, 1'b0);

    // R7: low-pass band never erased
    for (int p = 0; p < NP; p++) kcnt[p] = p % 4;
    run_block("R7", 1'b0, 0, 1'b1, 511, 1'b0);

    // R10: zero threshold keeps even empty planes
    for (int p = 0; p < NP; p++) kcnt[p] = 0;
    run_block("R10", 1'b0, 0, 1'b0, 0, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule